// File: doc/BRIEF.md
# Parallel Port Control-Word Sequencer

This block interprets the stream of control bytes that a processor writes to one port of a two-port parallel I/O controller. One copy sits behind each port. Each byte arrives with a one-cycle write strobe. The block turns the bytes into the port's operating settings: the operating mode, an 8-bit direction register, the interrupt enable, two monitoring flags and an 8-bit monitoring mask.

What a byte means depends on the bytes written before it. The block therefore keeps a small expectation state. Choosing bit-control mode makes the next byte a direction value. An interrupt word that announces a mask makes the next byte that mask. In both cases the parser then goes back to decoding control words. Announcing a mask also produces a one-cycle pulse that clears any pending interrupt in the port's interrupt logic.

Every setting is a registered output. Its new value is visible from the clock edge that samples the write.

Top module: `pio_ctl_seq`

## Requirements
- R1: After a synchronous reset the block shows the following state. The mode is input (1) and the interrupt enable is 0. The mask and the direction register are both 0xFF. The AND/OR and polarity flags are 0, the clear pulse is low, and the expectation is control (0).
- R2: This requirement applies while the expectation is control. A written byte whose bits 3:0 are 1111 loads the mode from bits 7:6. The mode codes are 0 output, 1 input, 2 bidirectional and 3 bit control.
- R3: A mode word that selects mode 3 moves the expectation to direction select (1). The next byte written is stored whole in the direction register, and the expectation then goes back to control (0).
- R4: This requirement applies while the expectation is control. A byte whose bits 3:0 are 0111 loads three fields: the interrupt enable from bit 7, the AND/OR flag from bit 6 (1 means AND) and the polarity flag from bit 5.
- R5: An interrupt control word (bits 3:0 = 0111) with bit 4 set moves the expectation to mask (2). The next byte written is stored whole as the monitoring mask, and the expectation then goes back to control.
- R6: The clear pulse is high for exactly the one cycle after an interrupt control word with bit 4 set, in any mode. At all other times it is low.
- R7: This requirement applies while the expectation is control. A byte whose bits 3:0 are 0011 loads the interrupt enable from bit 7 and changes no other setting.
- R8: This requirement applies while the expectation is control. A byte whose bits 3:0 are none of 1111, 0111 or 0011 changes no setting and no expectation, and produces no clear pulse.
- R9: The AND/OR flag, the polarity flag and the mask are stored whatever the current mode is.
- R10: A byte taken as direction or mask data is never decoded as a control word, even when its low nibble matches one.
- R11: No setting and no expectation changes in a cycle without a write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle strobe for a byte write |
| wr_data | input | 8 | Byte written by the processor |
| mode | output | 2 | Current operating mode |
| dir_sel | output | 8 | Direction register |
| mon_mask | output | 8 | Monitoring mask |
| int_en | output | 1 | Interrupt enable |
| mon_and | output | 1 | Monitoring combine: 1 AND, 0 OR |
| mon_high | output | 1 | Active monitoring polarity |
| expect_kind | output | 2 | Expected next byte: 0 control, 1 direction, 2 mask |
| irq_clear | output | 1 | One-cycle clear of a pending interrupt |

## Verification
The assertions assume three things about the inputs. Reset is synchronous. wr_data holds a defined value whenever wr_en is high. The strobe is sampled only at rising edges. The bench meets these assumptions by changing every input at the falling edge and by always driving wr_data with a defined byte. It writes directed sequences and then a long pseudo-random mix of strobed and idle cycles, so the parser passes through every expectation state, including data bytes that look like control words.

// File: rtl/pio_ctl_pkg.sv
package pio_ctl_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic [1:0] {
        MODE_OUT    = 2'd0,
        MODE_IN     = 2'd1,
        MODE_BIDIR  = 2'd2,
        MODE_BITCTL = 2'd3
    } port_mode_e;

    typedef enum logic [1:0] {
        EXP_CTRL   = 2'd0,
        EXP_DIRSEL = 2'd1,
        EXP_MASK   = 2'd2
    } expect_e;

    typedef enum logic [1:0] {
        CW_NONE    = 2'd0,
        CW_MODE    = 2'd1,
        CW_INTFULL = 2'd2,
        CW_INTEN   = 2'd3
    } cw_kind_e;

    localparam logic [NIB_W-1:0] NIB_MODE    = 4'b1111;
    localparam logic [NIB_W-1:0] NIB_INTFULL = 4'b0111;
    localparam logic [NIB_W-1:0] NIB_INTEN   = 4'b0011;

    typedef struct packed {
        cw_kind_e   kind;
        port_mode_e mode;
        logic       ien;
        logic       and_sel;
        logic       high_sel;
        logic       mask_next;
    } cw_fields_t;

    typedef struct packed {
        port_mode_e        mode;
        logic [BYTE_W-1:0] dir;
        logic [BYTE_W-1:0] mask;
        logic              ien;
        logic              and_sel;
        logic              high_sel;
    } settings_t;

    function automatic cw_fields_t classify(input logic [BYTE_W-1:0] b);
        cw_fields_t f;
        f.mode      = port_mode_e'(b[7:6]);
        f.ien       = b[7];
        f.and_sel   = b[6];
        f.high_sel  = b[5];
        f.mask_next = b[4];
        case (b[NIB_W-1:0])
            NIB_MODE:    f.kind = CW_MODE;
            NIB_INTFULL: f.kind = CW_INTFULL;
            NIB_INTEN:   f.kind = CW_INTEN;
            default:     f.kind = CW_NONE;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/pio_ctl_decode.sv
module pio_ctl_decode
    import pio_ctl_pkg::*;
(
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  expect_e           expect_q,
    output cw_fields_t        fields,
    output logic              take_ctrl,
    output logic              take_dir,
    output logic              take_mask
);
    always_comb begin
        fields    = classify(wr_data);
        take_ctrl = wr_en && (expect_q == EXP_CTRL) && (fields.kind != CW_NONE);
        take_dir  = wr_en && (expect_q == EXP_DIRSEL);
        take_mask = wr_en && (expect_q == EXP_MASK);
    end
endmodule

// File: rtl/pio_ctl_state.sv
module pio_ctl_state
    import pio_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take_ctrl,
    input  logic       take_dir,
    input  logic       take_mask,
    input  cw_fields_t fields,
    output expect_e    expect_q
);
    expect_e expect_d;

    always_comb begin
        expect_d = expect_q;
        if (take_dir || take_mask) begin
            expect_d = EXP_CTRL;
        end else if (take_ctrl) begin
            if (fields.kind == CW_MODE && fields.mode == MODE_BITCTL)
                expect_d = EXP_DIRSEL;
            else if (fields.kind == CW_INTFULL && fields.mask_next)
                expect_d = EXP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) expect_q <= EXP_CTRL;
        else     expect_q <= expect_d;
    end

    // R3: the state register never holds the unused code
    p_expect_legal_r3: assert property (@(posedge clk) disable iff (rst)
        expect_q != expect_e'(2'd3));

    // R3: a byte taken as direction data returns the parser to control
    p_dir_return_r3: assert property (@(posedge clk) disable iff (rst)
        take_dir |=> expect_q == EXP_CTRL);

    // R5: a byte taken as mask data returns the parser to control
    p_mask_return_r5: assert property (@(posedge clk) disable iff (rst)
        take_mask |=> expect_q == EXP_CTRL);

    // R11: with no load the expectation holds
    p_expect_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !(take_ctrl || take_dir || take_mask) |=> $stable(expect_q));
endmodule

// File: rtl/pio_ctl_regs.sv
module pio_ctl_regs
    import pio_ctl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MASK_RESET = 8'hFF,
    parameter logic [BYTE_W-1:0] DIR_RESET  = 8'hFF,
    parameter port_mode_e        MODE_RESET = MODE_IN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_ctrl,
    input  logic              take_dir,
    input  logic              take_mask,
    input  cw_fields_t        fields,
    input  logic [BYTE_W-1:0] wr_data,
    output settings_t         set_q,
    output logic              clr_q
);
    settings_t set_d;
    logic      clr_d;

    always_comb begin
        set_d = set_q;
        clr_d = 1'b0;
        if (take_dir)  set_d.dir  = wr_data;
        if (take_mask) set_d.mask = wr_data;
        if (take_ctrl) begin
            case (fields.kind)
                CW_MODE: set_d.mode = fields.mode;
                CW_INTFULL: begin
                    set_d.ien      = fields.ien;
                    set_d.and_sel  = fields.and_sel;
                    set_d.high_sel = fields.high_sel;
                    clr_d          = fields.mask_next;
                end
                CW_INTEN: set_d.ien = fields.ien;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q.mode     <= MODE_RESET;
            set_q.dir      <= DIR_RESET;
            set_q.mask     <= MASK_RESET;
            set_q.ien      <= 1'b0;
            set_q.and_sel  <= 1'b0;
            set_q.high_sel <= 1'b0;
            clr_q          <= 1'b0;
        end else begin
            set_q <= set_d;
            clr_q <= clr_d;
        end
    end

    // R11: settings hold when nothing is loaded
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(take_ctrl || take_dir || take_mask) |=> $stable(set_q));

    // R10: a data byte leaves mode and interrupt settings alone
    p_data_no_ctrl_r10: assert property (@(posedge clk) disable iff (rst)
        (take_dir || take_mask) |=>
            $stable(set_q.mode) && $stable(set_q.ien) &&
            $stable(set_q.and_sel) && $stable(set_q.high_sel));

    // R3: direction data lands whole in the direction register
    p_dir_load_r3: assert property (@(posedge clk) disable iff (rst)
        take_dir |=> set_q.dir == $past(wr_data));

    // R7: the enable-only word touches only the enable
    p_inten_only_r7: assert property (@(posedge clk) disable iff (rst)
        (take_ctrl && fields.kind == CW_INTEN) |=>
            $stable(set_q.mode) && $stable(set_q.mask) && $stable(set_q.dir) &&
            $stable(set_q.and_sel) && $stable(set_q.high_sel));
endmodule

// File: rtl/pio_ctl_seq.sv
module pio_ctl_seq
    import pio_ctl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MASK_RESET = 8'hFF,
    parameter logic [BYTE_W-1:0] DIR_RESET  = 8'hFF,
    parameter port_mode_e        MODE_RESET = MODE_IN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [1:0]        mode,
    output logic [BYTE_W-1:0] dir_sel,
    output logic [BYTE_W-1:0] mon_mask,
    output logic              int_en,
    output logic              mon_and,
    output logic              mon_high,
    output logic [1:0]        expect_kind,
    output logic              irq_clear
);
    expect_e    expect_q;
    cw_fields_t fields;
    logic       take_ctrl, take_dir, take_mask;
    settings_t  set_q;
    logic       clr_q;

    pio_ctl_decode u_decode (
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .expect_q  (expect_q),
        .fields    (fields),
        .take_ctrl (take_ctrl),
        .take_dir  (take_dir),
        .take_mask (take_mask)
    );

    pio_ctl_state u_state (
        .clk       (clk),
        .rst       (rst),
        .take_ctrl (take_ctrl),
        .take_dir  (take_dir),
        .take_mask (take_mask),
        .fields    (fields),
        .expect_q  (expect_q)
    );

    pio_ctl_regs #(
        .MASK_RESET (MASK_RESET),
        .DIR_RESET  (DIR_RESET),
        .MODE_RESET (MODE_RESET)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .take_ctrl (take_ctrl),
        .take_dir  (take_dir),
        .take_mask (take_mask),
        .fields    (fields),
        .wr_data   (wr_data),
        .set_q     (set_q),
        .clr_q     (clr_q)
    );

    assign mode        = set_q.mode;
    assign dir_sel     = set_q.dir;
    assign mon_mask    = set_q.mask;
    assign int_en      = set_q.ien;
    assign mon_and     = set_q.and_sel;
    assign mon_high    = set_q.high_sel;
    assign expect_kind = expect_q;
    assign irq_clear   = clr_q;

    // R6: a clear pulse always coincides with the parser waiting for a mask
    p_clr_opens_mask_r6: assert property (@(posedge clk) disable iff (rst)
        irq_clear |-> expect_kind == 2'd2);

    // R6: the clear pulse never lasts two cycles
    p_clr_single_r6: assert property (@(posedge clk) disable iff (rst)
        irq_clear |=> !irq_clear);

    // R8: an unrecognised control byte changes nothing
    p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && expect_kind == 2'd0 && wr_data[3:0] != 4'b1111 &&
         wr_data[3:0] != 4'b0111 && wr_data[3:0] != 4'b0011) |=>
            $stable(mode) && $stable(dir_sel) && $stable(mon_mask) &&
            $stable(int_en) && $stable(mon_and) && $stable(mon_high) &&
            expect_kind == 2'd0 && !irq_clear);

    // R2: mode changes only after a strobed write
    p_mode_needs_write_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode) |-> $past(wr_en));
endmodule

// File: tb/tb_pio_ctl_seq.sv
module tb_pio_ctl_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] mode, expect_kind;
    logic [7:0] dir_sel, mon_mask;
    logic       int_en, mon_and, mon_high, irq_clear;

    pio_ctl_seq dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .mode(mode), .dir_sel(dir_sel), .mon_mask(mon_mask),
        .int_en(int_en), .mon_and(mon_and), .mon_high(mon_high),
        .expect_kind(expect_kind), .irq_clear(irq_clear)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state: value expected after the coming edge
    int m_mode, m_dir, m_mask, m_ien, m_and, m_high, m_exp, m_clr;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(cur_req, "mode", int'(mode), m_mode);
        chk(cur_req, "dir", int'(dir_sel), m_dir);
        chk(cur_req, "mask", int'(mon_mask), m_mask);
        chk(cur_req, "int_en", int'(int_en), m_ien);
        chk(cur_req, "and", int'(mon_and), m_and);
        chk(cur_req, "high", int'(mon_high), m_high);
        chk(cur_req, "expect", int'(expect_kind), m_exp);
        chk(cur_req, "clear", int'(irq_clear), m_clr);
    endtask

    task automatic model_reset();
        m_mode = 1; m_dir = 'hFF; m_mask = 'hFF; m_ien = 0;
        m_and = 0; m_high = 0; m_exp = 0; m_clr = 0;
    endtask

    task automatic model_write(bit w, int d);
        int nib = d % 16;
        m_clr = 0;
        if (!w) begin
            cur_req = "R11";
        end else if (m_exp == 1) begin
            m_dir = d; m_exp = 0; cur_req = "R3";
        end else if (m_exp == 2) begin
            m_mask = d; m_exp = 0; cur_req = "R5";
        end else if (nib == 15) begin
            m_mode = d / 64;
            if (m_mode == 3) m_exp = 1;
            cur_req = "R2";
        end else if (nib == 7) begin
            m_ien = (d / 128) % 2; m_and = (d / 64) % 2; m_high = (d / 32) % 2;
            if ((d / 16) % 2 == 1) begin m_exp = 2; m_clr = 1; cur_req = "R6"; end
            else cur_req = "R4";
        end else if (nib == 3) begin
            m_ien = (d / 128) % 2; cur_req = "R7";
        end else begin
            cur_req = "R8";
        end
    endtask

    // compare at the falling edge, then drive for the next rising edge
    task automatic step(bit w, int d);
        @(negedge clk);
        compare_all();
        wr_en = w;
        wr_data = d[7:0];
        model_write(w, d);
    endtask

    task automatic settle();
        step(0, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        // R1: reset state compared in the first step
        settle();

        // R2: every mode code
        step(1, 'h0F); step(1, 'h4F); step(1, 'h8F); settle();
        // R3: bit control then direction byte that looks like a mode word
        step(1, 'hCF); step(0, 0);
        step(1, 'h3F); settle();
        // R10: explicit check that the direction byte did not act as mode
        @(negedge clk);
        chk("R10", "mode after dir byte", int'(mode), 3);
        chk("R3", "dir byte stored", int'(dir_sel), 'h3F);
        chk("R3", "expect back to control", int'(expect_kind), 0);
        settle();
        // R4: interrupt word without mask
        step(1, 'hA7); settle();
        step(1, 'h47); settle();
        // R5/R6: mask follows; mask byte looks like an enable word
        step(1, 'hF7); step(1, 'h03); settle();
        @(negedge clk);
        chk("R5", "mask stored", int'(mon_mask), 3);
        chk("R10", "enable unchanged by mask byte", int'(int_en), 1);
        settle();
        // R7: enable-only word
        step(1, 'h03); step(1, 'h83); settle();
        // R8: unrecognised bytes
        step(1, 'hFF - 'h0F + 'h05); step(1, 'h00); step(1, 'hEE); settle();
        // R9: settings stored in output mode
        step(1, 'h0F); step(1, 'h77); step(1, 'h5A); settle();
        @(negedge clk);
        chk("R9", "mask in output mode", int'(mon_mask), 'h5A);
        chk("R9", "and flag in output mode", int'(mon_and), 1);
        chk("R9", "high flag in output mode", int'(mon_high), 1);
        chk("R9", "mode kept output", int'(mode), 0);
        settle();

        // mixed pseudo-random traffic
        for (int i = 0; i < 4000; i++) begin
            int pick = $urandom_range(0, 9);
            int b = $urandom_range(0, 255);
            if (pick < 2) b = (b & 'hF0) | 'h0F;
            else if (pick < 4) b = (b & 'hF0) | 'h07;
            else if (pick < 5) b = (b & 'hF0) | 'h03;
            step(pick != 9 && $urandom_range(0, 3) != 0, b);
        end
        settle();
        settle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule